// File: doc/BRIEF.md
# Single-Wire Gamepad Responder

This block plays the controller side of a one-wire gamepad link on which every symbol takes a fixed 4 µs slot. The value of a symbol is set by the length of its low phase. A 3 µs low followed by 1 µs high is a 0. A 1 µs low followed by 3 µs high is a 1. A polling master pulls the shared line low to send a request of nine symbols: a start flag of 0, then an 8-bit command with its most significant bit first. When the request is the button-status query, the responder answers on the same line. The answer is 33 data symbols followed by a stop symbol.

The line is open-drain and has an external pull-up. The responder reads the line on `line_i` and asserts `line_oe` to pull it low. It pulls the line only during the low phase of its own reply symbols, and leaves it released at every other time. The button word comes from a parallel port and is captured when the request completes. A request with the wrong command, a wrong start flag, or an over-long low phase gets no answer. After any such request, and after every reply, the block goes back to listening. All timing is derived from the parameter `CLK_PER_US`, which is 50 for a 50 MHz clock and must be at least 2.

Top module: `gp_responder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `line_oe` is low and the block is listening for a request.
- R2: A received symbol decodes as 0 if the synchronized line stayed low for at least 2·`CLK_PER_US` clocks, and as 1 if it stayed low for fewer clocks.
- R3: A low phase longer than 5·`CLK_PER_US` clocks discards the partial request. The next falling edge starts a new nine-symbol request from its first symbol.
- R4: A reply is sent only when the nine symbols received are 0 followed by 0,0,0,0,0,0,1,1, which is command 0x03 sent MSB first. Every other nine-symbol sequence, including one whose start flag is 1, leaves `line_oe` low, and the block listens again.
- R5: `line_oe` first rises exactly 2·`CLK_PER_US` clocks after the first clock edge that samples `line_i` high at the end of the ninth request symbol. It stays low until then.
- R6: A reply is 34 back-to-back slots of 4·`CLK_PER_US` clocks each. In each slot, `line_oe` is high for the first 3·`CLK_PER_US` clocks for a 0 and for the first `CLK_PER_US` clocks for a 1. It is low for the rest of the slot.
- R7: Reply slot i (i = 0..32) carries `buttons_i[i]`, so bit 0 goes first. Slot 33 is a stop symbol of value 1.
- R8: The word sent is the value of `buttons_i` at request completion. Changes to `buttons_i` after that point do not alter the reply.
- R9: Activity on `line_i` between request completion and the end of the reply is ignored. After the last reply slot, the block accepts the next request.
- R10: `line_oe` is never high outside a reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CLK_PER_US` cycles per microsecond |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Sampled level of the shared data line (asynchronous) |
| buttons_i | input | 33 | Button word offered for the next reply |
| line_oe | output | 1 | High to pull the shared line low; low releases it |

## Verification
The bench builds the block with `CLK_PER_US` = 4. This gives 16-clock slots, an 8-clock decode threshold, a 20-clock abort limit and an 8-clock turnaround. At that scale, every one of the 256 command values can be sent after a valid start flag, each checked for reply or silence. Every low-phase length from 1 to 21 clocks can also be swept through the decode threshold and past the abort limit. Each reply is compared cycle by cycle against slot shapes worked out arithmetically from the captured word.

// File: rtl/gp_pkg.sv
package gp_pkg;

    // Symbols in one request: start flag plus 8 command bits
    localparam int REQ_SYMS   = 9;
    // Width of the reply data word and number of reply slots (data plus stop)
    localparam int WORD_W     = 33;
    localparam int REPLY_SYMS = WORD_W + 1;

    // Expected request as shifted in, first symbol in the MSB:
    // start flag 0, then command 0x03 most significant bit first
    localparam logic [REQ_SYMS-1:0] QUERY_REQ = 9'h003;

    typedef enum logic [1:0] {
        ST_LISTEN = 2'd0,
        ST_GAP    = 2'd1,
        ST_REPLY  = 2'd2
    } gp_state_e;

    // One-cycle report from the symbol receiver
    typedef struct packed {
        logic valid;   // a complete symbol ended on this cycle
        logic value;   // its decoded value
        logic abort;   // low phase ran past the limit
    } rx_sym_t;

    function automatic int clks(input int per_us, input int n_us);
        return per_us * n_us;
    endfunction

endpackage

// File: rtl/gp_line_sync.sv
module gp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_s,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= line_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], line_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign line_s = chain[STAGES-1];
    assign fall   = prev & ~line_s;
    assign rise   = ~prev & line_s;
endmodule

// File: rtl/gp_sym_rx.sv
module gp_sym_rx
    import gp_pkg::*;
#(
    parameter int CLK_PER_US = 50
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    fall,
    input  logic    rise,
    output rx_sym_t sym
);
    localparam int THRESH  = clks(CLK_PER_US, 2);
    localparam int TIMEOUT = clks(CLK_PER_US, 5);
    localparam int CW      = $clog2(TIMEOUT + 1);

    logic          in_low;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            in_low  <= 1'b0;
            low_cnt <= '0;
            sym     <= '0;
        end else begin
            sym <= '0;
            if (fall) begin
                in_low  <= 1'b1;
                low_cnt <= CW'(1);
            end else if (in_low) begin
                if (rise) begin
                    in_low    <= 1'b0;
                    sym.valid <= 1'b1;
                    sym.value <= (low_cnt < CW'(THRESH));
                end else if (low_cnt >= CW'(TIMEOUT)) begin
                    in_low    <= 1'b0;
                    sym.abort <= 1'b1;
                end else begin
                    low_cnt <= low_cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/gp_reply_tx.sv
module gp_reply_tx
    import gp_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int SYMS       = REPLY_SYMS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [SYMS-1:0]          frame,
    output logic                     drive,
    output logic                     busy,
    output logic                     last,
    output logic [$clog2(SYMS)-1:0]  idx,
    output logic [$clog2(clks(CLK_PER_US, 4))-1:0] slot
);
    localparam int SLOT = clks(CLK_PER_US, 4);
    localparam int LONG = clks(CLK_PER_US, 3);
    localparam int SHRT = clks(CLK_PER_US, 1);
    localparam int SW   = $clog2(SLOT);
    localparam int IW   = $clog2(SYMS);

    logic [SW-1:0] low_len;

    assign last    = busy && (idx == IW'(SYMS - 1)) && (slot == SW'(SLOT - 1));
    assign low_len = frame[idx] ? SW'(SHRT) : SW'(LONG);
    assign drive   = busy && (slot < low_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            slot <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
            slot <= '0;
        end else if (busy) begin
            if (slot == SW'(SLOT - 1)) begin
                slot <= '0;
                if (last) busy <= 1'b0;
                else      idx  <= idx + IW'(1);
            end else begin
                slot <= slot + SW'(1);
            end
        end
    end
endmodule

// File: rtl/gp_responder.sv
module gp_responder
    import gp_pkg::*;
#(
    parameter int CLK_PER_US = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic [WORD_W-1:0] buttons_i,
    output logic              line_oe
);
    localparam int GAP      = clks(CLK_PER_US, 2);
    // Pipeline from pin to drive: two sync flops, edge register,
    // symbol register; the gap counter covers the remainder.
    localparam int PIPE     = 4;
    localparam int GAP_LOAD = GAP - PIPE;
    localparam int GW       = $clog2(GAP + 1);
    localparam int SW       = $clog2(clks(CLK_PER_US, 4));
    localparam int IW       = $clog2(REPLY_SYMS);

    gp_state_e             state;
    logic [3:0]            sym_cnt;
    logic [REQ_SYMS-2:0]   req_sr;
    logic [REQ_SYMS-1:0]   req_next;
    logic [GW-1:0]         gap_cnt;
    logic [WORD_W-1:0]     word_q;
    logic                  line_s, fall, rise;
    rx_sym_t               sym;
    logic                  tx_start, tx_busy, tx_last;
    logic [IW-1:0]         tx_idx;
    logic [SW-1:0]         tx_slot;

    gp_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .line_i(line_i),
        .line_s(line_s), .fall(fall), .rise(rise)
    );

    gp_sym_rx #(.CLK_PER_US(CLK_PER_US)) u_rx (
        .clk(clk), .rst(rst), .en(state == ST_LISTEN),
        .fall(fall), .rise(rise), .sym(sym)
    );

    gp_reply_tx #(.CLK_PER_US(CLK_PER_US), .SYMS(REPLY_SYMS)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start),
        .frame({1'b1, word_q}),
        .drive(line_oe), .busy(tx_busy), .last(tx_last),
        .idx(tx_idx), .slot(tx_slot)
    );

    assign req_next = {req_sr, sym.value};
    assign tx_start = (state == ST_GAP) && (gap_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_LISTEN;
            sym_cnt <= '0;
            req_sr  <= '0;
            gap_cnt <= '0;
            word_q  <= '0;
        end else begin
            case (state)
                ST_LISTEN: begin
                    if (sym.abort) begin
                        sym_cnt <= '0;
                    end else if (sym.valid) begin
                        if (sym_cnt == 4'(REQ_SYMS - 1)) begin
                            sym_cnt <= '0;
                            if (req_next == QUERY_REQ) begin
                                state   <= ST_GAP;
                                gap_cnt <= GW'(GAP_LOAD);
                                word_q  <= buttons_i;
                            end
                        end else begin
                            sym_cnt <= sym_cnt + 4'd1;
                            req_sr  <= req_next[REQ_SYMS-2:0];
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == '0) state <= ST_REPLY;
                    else               gap_cnt <= gap_cnt - GW'(1);
                end
                ST_REPLY: begin
                    if (tx_last) state <= ST_LISTEN;
                end
                default: state <= ST_LISTEN;
            endcase
        end
    end
endmodule

// File: rtl/gp_responder_chk.sv
module gp_responder_chk
    import gp_pkg::*;
#(
    parameter int CLK_PER_US = 50
) (
    input logic                clk,
    input logic                rst,
    input logic                line_oe,
    input gp_state_e           state,
    input logic [3:0]          sym_cnt,
    input rx_sym_t             sym,
    input logic [$clog2(clks(CLK_PER_US, 2) + 1)-1:0] gap_cnt,
    input logic [WORD_W-1:0]   word_q,
    input logic                tx_busy,
    input logic                tx_last,
    input logic [$clog2(REPLY_SYMS)-1:0] tx_idx,
    input logic [$clog2(clks(CLK_PER_US, 4))-1:0] tx_slot
);
    localparam int SW   = $clog2(clks(CLK_PER_US, 4));
    localparam int IW   = $clog2(REPLY_SYMS);
    localparam int LONG = clks(CLK_PER_US, 3);
    localparam int SHRT = clks(CLK_PER_US, 1);

    p_reset_listen_r1: assert property (@(posedge clk)
        rst |=> (state == ST_LISTEN && !line_oe));

    p_abort_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LISTEN && sym.abort) |=> (sym_cnt == 4'd0));

    p_gap_to_reply_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && gap_cnt == '0) |=> (state == ST_REPLY && line_oe));

    p_min_low_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && tx_slot < SW'(SHRT)) |-> line_oe);

    p_release_tail_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && tx_slot >= SW'(LONG)) |-> !line_oe);

    p_stop_is_one_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && tx_idx == IW'(REPLY_SYMS - 1) && tx_slot >= SW'(SHRT)) |-> !line_oe);

    p_word_held_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_LISTEN && $past(state) != ST_LISTEN) |-> $stable(word_q));

    p_back_to_listen_r9: assert property (@(posedge clk) disable iff (rst)
        tx_last |=> (state == ST_LISTEN && !line_oe));

    p_quiet_outside_r10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_REPLY) |-> !line_oe);
endmodule

bind gp_responder gp_responder_chk #(.CLK_PER_US(CLK_PER_US)) u_chk (
    .clk(clk), .rst(rst), .line_oe(line_oe), .state(state),
    .sym_cnt(sym_cnt), .sym(sym), .gap_cnt(gap_cnt), .word_q(word_q),
    .tx_busy(tx_busy), .tx_last(tx_last), .tx_idx(tx_idx), .tx_slot(tx_slot)
);

// File: tb/sim_gp_responder.sv
module sim_gp_responder;
    localparam int US    = 4;
    localparam int SLOT  = 4 * US;
    localparam int LONG  = 3 * US;
    localparam int SHRT  = US;
    localparam int THR   = 2 * US;
    localparam int TOUT  = 5 * US;
    localparam int GAP   = 2 * US;
    localparam int NSYM  = 34;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mline = 1'b1;
    logic [32:0] buttons = '0;
    logic        line_oe;
    logic        line_w;
    int          checks = 0;
    int          failures = 0;

    always #10 clk = ~clk;

    // open-drain line with pull-up: either side may pull low
    assign line_w = line_oe ? 1'b0 : mline;

    gp_responder #(.CLK_PER_US(US)) u0 (
        .clk(clk), .rst(rst), .line_i(line_w),
        .buttons_i(buttons), .line_oe(line_oe)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Send nine symbols, seq[8] first; last_lo overrides the ninth low length.
    // Returns at the negedge where the line was released after the ninth low.
    task automatic send_req(input logic [8:0] seq, input int last_lo);
        for (int i = 8; i >= 0; i--) begin
            int lo;
            lo = seq[i] ? SHRT : LONG;
            if (i == 0 && last_lo > 0) lo = last_lo;
            mline = 1'b0;
            repeat (lo) @(negedge clk);
            mline = 1'b1;
            if (i != 0) repeat (SLOT - lo) @(negedge clk);
        end
    endtask

    task automatic expect_reply(input logic [32:0] w, input bit flip, input bit glitch);
        int bad;
        bad = 0;
        for (int j = 1; j <= GAP; j++) begin
            @(negedge clk);
            if (line_oe) bad++;
            if (glitch && j == 2) mline = 1'b0;
            if (glitch && j == 5) mline = 1'b1;
            if (flip && j == GAP) buttons = ~buttons;
        end
        check(bad == 0, "R5 early drive", bad, 0);
        for (int s = 0; s < NSYM; s++) begin
            bit b;
            b = (s == NSYM - 1) ? 1'b1 : w[s];
            bad = 0;
            for (int p = 0; p < SLOT; p++) begin
                @(negedge clk);
                if (glitch && s == 3 && p == 13) mline = 1'b0;
                if (glitch && s == 3 && p == 15) mline = 1'b1;
                if (line_oe !== (p < (b ? SHRT : LONG))) bad++;
            end
            check(bad == 0, (s == NSYM - 1) ? "R7 stop slot" : "R6 R7 data slot", bad, 0);
        end
        bad = 0;
        for (int j = 0; j < 2 * SLOT; j++) begin
            @(negedge clk);
            if (line_oe) bad++;
        end
        check(bad == 0, "R9 R10 after reply", bad, 0);
    endtask

    task automatic expect_silent(input string tag);
        int bad;
        bad = 0;
        for (int j = 0; j < GAP + 3 * SLOT; j++) begin
            @(negedge clk);
            if (line_oe) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [32:0] pats [6];
        pats[0] = 33'h0_0000_0000;
        pats[1] = 33'h1_FFFF_FFFF;
        pats[2] = 33'h1_5555_5555;
        pats[3] = 33'h0_AAAA_AAAA;
        pats[4] = 33'h1_0000_0001;
        pats[5] = 33'h0_DEAD_BEEF;

        repeat (3) @(negedge clk);
        check(line_oe == 1'b0, "R1 in reset", line_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        check(line_oe == 1'b0, "R1 after reset", line_oe, 0);
        repeat (SLOT) @(negedge clk);

        // R6 R7: several button words, back-to-back polls (R9)
        for (int k = 0; k < 6; k++) begin
            buttons = pats[k];
            send_req(9'h003, 0);
            expect_reply(pats[k], 1'b0, 1'b0);
        end

        // R8: word changes during gap and reply do not reach the line
        buttons = 33'h1_2345_6789;
        send_req(9'h003, 0);
        expect_reply(33'h1_2345_6789, 1'b1, 1'b0);

        // R9: master pulls the line during gap and reply; ignored
        buttons = 33'h0_0F0F_3C3C;
        send_req(9'h003, 0);
        expect_reply(33'h0_0F0F_3C3C, 1'b0, 1'b1);

        // R4: every command with a 0 start flag
        for (int c = 0; c < 256; c++) begin
            if (c == 3) begin
                buttons = 33'h1_8000_0003;
                send_req({1'b0, 8'(c)}, 0);
                expect_reply(33'h1_8000_0003, 1'b0, 1'b0);
            end else begin
                send_req({1'b0, 8'(c)}, 0);
                expect_silent("R4 wrong command");
            end
            repeat (4) @(negedge clk);
        end

        // R4: start flag of 1
        send_req(9'h103, 0);
        expect_silent("R4 start flag 1");

        // R2: sweep ninth low length; below THR decodes 1 (query), else 0
        for (int L = 1; L <= TOUT; L++) begin
            buttons = 33'(L) * 33'h0_0101_0101;
            send_req(9'h003, L);
            if (L < THR) expect_reply(33'(L) * 33'h0_0101_0101, 1'b0, 1'b0);
            else         expect_silent("R2 long low decodes 0");
        end

        // R3: low past the limit aborts
        send_req(9'h003, TOUT + 1);
        expect_silent("R3 over-long low");

        // R3: partial request discarded, fresh request then answered
        for (int i = 0; i < 5; i++) begin
            mline = 1'b0;
            repeat (LONG) @(negedge clk);
            mline = 1'b1;
            repeat (SLOT - LONG) @(negedge clk);
        end
        mline = 1'b0;
        repeat (TOUT + 10) @(negedge clk);
        mline = 1'b1;
        repeat (SLOT) @(negedge clk);
        buttons = 33'h0_7777_1234;
        send_req(9'h003, 0);
        expect_reply(33'h0_7777_1234, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule